// File: doc/BRIEF.md
# Restartable Counted Loop Branch Unit

This unit executes a counted loop-branch operation for a simple in-order core. Each accepted operation receives the counter register, the sequential next instruction pointer, an 8-bit signed displacement, an address-size mode, a segment limit and two page-present lookup results. One cycle later the unit returns the updated counter, the next instruction pointer, a taken flag and a fault cause. No arithmetic status flags are read or written, so the operation can close a loop whose body keeps a carry or overflow chain alive.

Two operations are supported. The loop operation decrements the counter and branches while the result is nonzero. The zero-test operation branches when the counter is zero and leaves it untouched. The address-size mode sets the counter width and whether the target is truncated. The counter update is computed speculatively. A copy of the incoming counter is always captured alongside it, and that copy is returned whenever the branch half of the operation faults, so the faulting instruction can be restarted without any reconstruction arithmetic.

Top module: `loop_branch_unit`

## Requirements
- R1: After reset `res_valid` is 0 and `op_ready` is 1.
- R2: Every cycle with `op_valid` high produces exactly one result with `res_valid` high on the following cycle, and no result appears otherwise.
- R3: With `op_kind`=0 the counter is decremented by one; the branch is taken when the decremented counter (within the selected width) is nonzero, otherwise `ip_out` is the sequential address `ip_seq`.
- R4: `size_mode` 2'b00 decrements bits 15:0 and keeps bits 63:16; 2'b01 decrements bits 31:0 and clears bits 63:32; 2'b10 or 2'b11 decrements all 64 bits; in every width a zero counter wraps to all ones.
- R5: The branch target is `ip_seq` plus the sign-extended `disp`; in mode 2'b01 the target is truncated to its low 32 bits with bits 63:32 cleared.
- R6: With `op_kind`=1 the counter is returned unchanged and the branch is taken exactly when the counter within the selected width is zero.
- R7: If the chosen next address (target when branching, `ip_seq` otherwise) is above `seg_limit`, the result has `fault`=1, `fault_cause`=2'b01, and `cnt_out` equals the pre-operation counter.
- R8: Otherwise, if the page flag for the chosen address (`page_ok_tgt` when branching, `page_ok_seq` otherwise) is 0, the result has `fault_cause`=2'b10 and the pre-operation counter; the flag of the address not chosen has no effect; a segment fault takes priority.
- R9: `taken` and `fault` are never both 1, and `fault_cause` is 2'b00 whenever `fault` is 0.
- R10: On a fault `ip_out` carries the faulting (chosen) address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation presented |
| op_ready | output | 1 | Unit accepts an operation this cycle |
| op_kind | input | 1 | 0 loop (decrement and branch), 1 branch if counter zero |
| size_mode | input | 2 | 00 16-bit, 01 32-bit, 10/11 64-bit |
| cnt_in | input | 64 | Counter register value before the operation |
| ip_seq | input | 64 | Address of the next sequential instruction |
| disp | input | 8 | Signed branch displacement |
| seg_limit | input | 64 | Highest legal address in the code segment |
| page_ok_tgt | input | 1 | Page of the branch target is present |
| page_ok_seq | input | 1 | Page of the sequential address is present |
| res_valid | output | 1 | Result valid |
| cnt_out | output | 64 | Counter to write back |
| ip_out | output | 64 | Next instruction pointer, or faulting address |
| taken | output | 1 | Branch taken |
| fault | output | 1 | Operation faulted |
| fault_cause | output | 2 | 00 none, 01 segment limit, 10 page not present |

## Verification
Counters that become nonzero, exactly zero and wrapped from zero are applied in each width. This separates the branch decision from the width masking and shows whether upper bits are kept or cleared. Targets that cross the 32-bit boundary in mode 01 expose a missing truncation. Faults are injected on the target and on the sequential address, with the page flag of the unused address deliberately cleared, so that checking the wrong address or restoring a wrong counter shows up as a mismatch. A run of random operations back to back follows, to catch state leaking between results.

// File: rtl/loop_branch_unit.sv
module loop_branch_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  output logic        op_ready,
  input  logic        op_kind,
  input  logic [1:0]  size_mode,
  input  logic [63:0] cnt_in,
  input  logic [63:0] ip_seq,
  input  logic [7:0]  disp,
  input  logic [63:0] seg_limit,
  input  logic        page_ok_tgt,
  input  logic        page_ok_seq,
  output logic        res_valid,
  output logic [63:0] cnt_out,
  output logic [63:0] ip_out,
  output logic        taken,
  output logic        fault,
  output logic [1:0]  fault_cause
);

  localparam logic [1:0] SZ16 = 2'b00;
  localparam logic [1:0] SZ32 = 2'b01;
  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_SEG  = 2'b01;
  localparam logic [1:0] CAUSE_PAGE = 2'b10;

  function automatic logic width_zero(input logic [63:0] v, input logic [1:0] m);
    case (m)
      SZ16:    width_zero = (v[15:0] == 16'd0);
      SZ32:    width_zero = (v[31:0] == 32'd0);
      default: width_zero = (v == 64'd0);
    endcase
  endfunction

  logic [63:0] tgt_full, tgt, dec_cnt, spec_cnt, next_addr;
  logic        go, seg_bad, page_bad;
  logic [1:0]  cause;

  assign op_ready = 1'b1;
  assign tgt_full = ip_seq + {{56{disp[7]}}, disp};
  assign tgt      = (size_mode == SZ32) ? {32'd0, tgt_full[31:0]} : tgt_full;

  always_comb begin
    case (size_mode)
      SZ16:    dec_cnt = {cnt_in[63:16], cnt_in[15:0] - 16'd1};
      SZ32:    dec_cnt = {32'd0, cnt_in[31:0] - 32'd1};
      default: dec_cnt = cnt_in - 64'd1;
    endcase
  end

  assign go        = op_kind ? width_zero(cnt_in, size_mode) : !width_zero(dec_cnt, size_mode);
  assign spec_cnt  = op_kind ? cnt_in : dec_cnt;
  assign next_addr = go ? tgt : ip_seq;
  assign seg_bad   = next_addr > seg_limit;
  assign page_bad  = go ? !page_ok_tgt : !page_ok_seq;
  assign cause     = seg_bad ? CAUSE_SEG : (page_bad ? CAUSE_PAGE : CAUSE_NONE);

  logic [63:0] spec_q, saved_q, addr_q;
  logic        go_q;
  logic [1:0]  cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      spec_q    <= '0;
      saved_q   <= '0;
      addr_q    <= '0;
      go_q      <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        spec_q  <= spec_cnt;
        saved_q <= cnt_in;
        addr_q  <= next_addr;
        go_q    <= go;
        cause_q <= cause;
      end
    end
  end

  assign fault       = res_valid && (cause_q != CAUSE_NONE);
  assign fault_cause = res_valid ? cause_q : CAUSE_NONE;
  assign taken       = res_valid && go_q && (cause_q == CAUSE_NONE);
  assign cnt_out     = (cause_q != CAUSE_NONE) ? saved_q : spec_q;
  assign ip_out      = addr_q;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);  // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);  // R2
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(taken && fault));  // R9
  AST_CAUSE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !fault) |-> (fault_cause == CAUSE_NONE));  // R9
  AST_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (!fault || cnt_out == $past(cnt_in)));  // R7
  AST_ZTEST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind) |=> (cnt_out == $past(cnt_in)));  // R6
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && size_mode == SZ16) |=> (cnt_out[63:16] == $past(cnt_in[63:16])));  // R4

endmodule

// File: tb/loop_branch_unit_test.sv
module loop_branch_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_kind = 1'b0, page_ok_tgt = 1'b1, page_ok_seq = 1'b1;
  logic [1:0] size_mode = 2'b00;
  logic [63:0] cnt_in = '0, ip_seq = '0, seg_limit = '1;
  logic [7:0] disp = '0;
  logic op_ready, res_valid, taken, fault;
  logic [63:0] cnt_out, ip_out;
  logic [1:0] fault_cause;
  int checks = 0, fails = 0;

  typedef struct {
    logic [63:0] cnt;
    logic [63:0] ip;
    logic        tk;
    logic [1:0]  cause;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  loop_branch_unit uut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(logic k, logic [1:0] m, logic [63:0] c, logic [63:0] ip,
                                 logic [7:0] d, logic [63:0] lim, logic pt, logic ps, string tag);
    exp_t e;
    logic [63:0] mask, low, nc, tg, nxt;
    logic br;
    mask = (m == 2'b00) ? 64'hFFFF : (m == 2'b01) ? 64'hFFFF_FFFF : '1;
    if (k) begin
      nc = c;
      br = ((c & mask) == 0);
    end else begin
      low = ((c & mask) - 64'd1) & mask;
      if (m == 2'b00) nc = (c & ~mask) | low;
      else nc = low;
      br = (low != 0);
    end
    tg = ip + 64'($signed(d));
    if (m == 2'b01) tg = tg & 64'hFFFF_FFFF;
    nxt = br ? tg : ip;
    e.ip = nxt;
    e.tag = tag;
    if (nxt > lim) e.cause = 2'b01;
    else if (!(br ? pt : ps)) e.cause = 2'b10;
    else e.cause = 2'b00;
    e.cnt = (e.cause != 0) ? c : nc;
    e.tk = br && (e.cause == 0);
    return e;
  endfunction

  task automatic drive(string tag, logic k, logic [1:0] m, logic [63:0] c, logic [63:0] ip,
                       logic [7:0] d, logic [63:0] lim, logic pt, logic ps);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; size_mode = m; cnt_in = c; ip_seq = ip;
    disp = d; seg_limit = lim; page_ok_tgt = pt; page_ok_seq = ps;
    sb.push_back(model(k, m, c, ip, d, lim, pt, ps, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R2 res_valid", 64'(res_valid), 64'(sb.size() != 0));
      if (res_valid && sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " cnt_out"}, cnt_out, e.cnt);
        chk({e.tag, " ip_out"}, ip_out, e.ip);
        chk({e.tag, " R9 taken"}, 64'(taken), 64'(e.tk));
        chk({e.tag, " R9 fault"}, 64'(fault), 64'(e.cause != 0));
        chk({e.tag, " fault_cause"}, 64'(fault_cause), 64'(e.cause));
      end
    end
  end

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 res_valid", 64'(res_valid), 64'd0);
    chk("R1 op_ready", 64'(op_ready), 64'd1);
    rst_n = 1'b1;
    // R3 R4: 16-bit taken, upper bits kept
    drive("R3 R4 16b taken", 0, 2'b00, 64'h1234_5678_9ABC_0005, 64'h1000, 8'h10, '1, 1, 1);
    // R3: 16-bit reaches zero, falls through
    drive("R3 16b fall", 0, 2'b00, 64'hFFFF_0000_0000_0001, 64'h2000, 8'h10, '1, 1, 1);
    // R4: 16-bit wrap from zero
    drive("R4 16b wrap", 0, 2'b00, 64'hAAAA_BBBB_CCCC_0000, 64'h3000, 8'hF0, '1, 1, 1);
    // R4 R5: 32-bit wrap with zero-extension and target truncation
    drive("R4 R5 32b wrap trunc", 0, 2'b01, 64'hDEAD_BEEF_0000_0000, 64'h0000_0001_0000_0004, 8'hF8, '1, 1, 1);
    drive("R5 32b carry trunc", 0, 2'b01, 64'h0000_0000_0000_0007, 64'h0000_0000_FFFF_FFF8, 8'h20, '1, 1, 1);
    // R4: 64-bit wrap and fall
    drive("R4 64b wrap", 0, 2'b10, 64'd0, 64'h0000_1234_0000_0080, 8'h80, '1, 1, 1);
    drive("R3 64b fall", 0, 2'b11, 64'd1, 64'h4000, 8'h7F, '1, 1, 1);
    // R6: zero-test variant
    drive("R6 ztest zero", 1, 2'b00, 64'h5555_0000_0000_0000, 64'h5000, 8'h40, '1, 1, 1);
    drive("R6 ztest nonzero", 1, 2'b01, 64'h0000_0000_0000_0100, 64'h5000, 8'h40, '1, 1, 1);
    drive("R6 ztest 64", 1, 2'b10, 64'h8000_0000_0000_0000, 64'h5000, 8'h40, '1, 1, 1);
    // R7 R10: segment faults on target and on sequential address
    drive("R7 R10 seg tgt", 0, 2'b10, 64'h0000_0000_0000_0009, 64'h0FF0, 8'h20, 64'h1000, 1, 1);
    drive("R7 R10 seg seq", 0, 2'b00, 64'h0000_0000_0000_0001, 64'h1001, 8'hE0, 64'h1000, 1, 1);
    // R8: page faults, unused flag ignored, segment priority
    drive("R8 R10 page tgt", 0, 2'b01, 64'h0000_0000_0000_0003, 64'h6000, 8'h10, '1, 0, 1);
    drive("R8 unused tgt flag", 0, 2'b01, 64'h0000_0000_0000_0001, 64'h6000, 8'h10, '1, 0, 1);
    drive("R8 page seq", 1, 2'b00, 64'h0000_0000_0000_0001, 64'h7000, 8'h10, '1, 1, 0);
    drive("R8 unused seq flag", 0, 2'b10, 64'd5, 64'h7000, 8'h10, '1, 1, 0);
    drive("R7 R8 seg priority", 0, 2'b10, 64'd5, 64'h7000, 8'h10, 64'h6000, 0, 0);
    idle();
    idle();
    for (int i = 0; i < 200; i++) begin
      logic [63:0] c;
      c = {$urandom, $urandom};
      if (i % 4 == 0) c[31:0] = 32'd1;
      if (i % 7 == 0) c[15:0] = 16'd0;
      drive("R3 R7 R8 random", 1'($urandom), 2'($urandom), c, {32'd0, $urandom},
            8'($urandom), (i % 5 == 0) ? {32'd0, $urandom} : '1, 1'($urandom % 4 != 0), 1'($urandom % 4 != 0));
      if (i % 9 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    chk("R2 queue drained", 64'(sb.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule